// File: doc/BRIEF.md
# Dual Countdown Timer

A register-mapped peripheral holding two independent 24-bit down-counters. Each counter has its own prescaler. It can stop after its first expiry (one-shot) or reload itself and run for ever (periodic). A single synchronous register port reaches the per-timer control words, the reload values, a live count view of the second timer and a shared pending-flag register. Each timer sets a pending flag when it expires. Its interrupt line is that flag gated by its interrupt-enable bit. Software clears flags by writing ones to the shared flag register.

Every channel is a three-state machine:
- **Idle**: the counter is frozen.
- **Prime**: the channel is running and waits for the next prescaled tick to copy the reload value into the counter.
- **Count**: the counter decrements once per prescaled tick.

The transitions are:
- Idle→Prime: enable is set while the counter is zero or a reload written during Idle is pending.
- Idle→Count: enable is set with a nonzero count and no pending reload, which resumes from the held count.
- Prime→Count: a tick loads the counter.
- Count→Prime: the reload value is written while running.
- Count→Count: a periodic expiry reloads the counter.
- Prime→Idle or Count→Idle: enable is cleared by software, or a one-shot expiry clears it.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset every mapped register reads 0 and both interrupt lines are low.
- R2: A control word holds enable at bit 30, interrupt enable at bit 29, mode at bits 28:27 and the prescale value P at bits 7:0. The other bits read 0. Control words sit at 0x0 (timer 0) and 0x4 (timer 1). Reload values sit at 0x8 and 0xC and keep 24 bits. Timer 1's count reads at 0x14 and the flags read at 0x18, bit n for timer n. Any other offset reads 0.
- R3: While running, the counter changes only once every P+1 clocks, and it goes down by exactly one in each such step.
- R4: Enable may be written at clock edge E0 while the counter is zero or a reload was written while stopped. The flag then rises at edge E0+(L+1)(P+1), where L is the reload value. In one-shot mode (bit 27 clear) enable then reads 0 and the count reads 0.
- R5: In periodic mode (bit 27 set) the counter reloads at each expiry, and later expiries follow every L(P+1) clocks.
- R6: The flag sets on expiry whether or not interrupt enable is set, and interrupt line n equals flag n AND interrupt enable n.
- R7: Writing 1 to bit n at 0x18 clears flag n, and zero bits leave their flag alone. An expiry in the same cycle as the clear wins, and the flag stays set.
- R8: Clearing enable freezes the count. Setting it again resumes from the held value, with the prescaler restarted, so the first decrement comes P+1 clocks after the enabling edge.
- R9: Writing a reload value while a timer runs makes the next prescaled tick load that value.
- R10: A reload value of 0 never expires, and enable stays set.
- R11: The two timers are independent. Activity on one never changes the other's flag or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 2 | Interrupt line per timer |

## Verification
Two events can land in the same cycle: an expiry that sets a flag, and a software write that clears the same flag. The bench runs timer 0 periodically with a known period and computes the exact edges at which it expires. It places one clear write away from an expiry, where the flag must drop. It places another clear write exactly on an expiry edge, where the flag must remain set. The same exact-edge arithmetic is used to sweep the one-shot delay over four prescale values and four reload values.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int NUM_TMR   = 2;
    localparam int RUN_BIT   = 30;
    localparam int IEN_BIT   = 29;
    localparam int MODE_LO   = 27;
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_LOAD  = 'h08;
    localparam int OFF_CNT1  = 'h14;
    localparam int OFF_FLAGS = 'h18;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRIME,
        ST_COUNT
    } tmr_state_e;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [PSC_W-1:0] limit,
    output logic             tick
);
    logic [PSC_W-1:0] div_q;

    assign tick = active && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n || !active || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/dct_channel.sv
module dct_channel
    import dct_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             load_we,
    input  logic             wr_run,
    input  logic             wr_ien,
    input  logic [1:0]       wr_mode,
    input  logic [PSC_W-1:0] wr_psc,
    input  logic [CNT_W-1:0] wr_load,
    output logic             run_q,
    output logic             ien_q,
    output logic [1:0]       mode_q,
    output logic [PSC_W-1:0] psc_q,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);
    tmr_state_e       state_q, state_d;
    logic             pend_q, pend_d;
    logic             run_d;
    logic             tick;
    logic             active;
    logic             periodic;
    logic [CNT_W-1:0] count_d;

    assign periodic = mode_q[0];
    assign active   = (state_q != ST_IDLE);

    dct_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .limit  (psc_q),
        .tick   (tick)
    );

    assign expire = (state_q == ST_COUNT) && tick && (count_q == CNT_W'(1));

    // next-state process
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            run_d = wr_run;
        end else if (expire && !periodic) begin
            run_d = 1'b0;
        end else begin
            run_d = run_q;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (run_d) begin
                    state_d = (pend_q || load_we || count_q == '0) ? ST_PRIME : ST_COUNT;
                end
            end
            ST_PRIME: begin
                if (!run_d)       state_d = ST_IDLE;
                else if (load_we) state_d = ST_PRIME;
                else if (tick)    state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!run_d)       state_d = ST_IDLE;
                else if (load_we) state_d = ST_PRIME;
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_d == ST_PRIME)                 pend_d = 1'b0;
        else if (load_we && state_q == ST_IDLE)  pend_d = 1'b1;
        else                                     pend_d = pend_q;
    end

    // datapath / output process
    always_comb begin
        count_d = count_q;
        if (tick) begin
            unique case (state_q)
                ST_PRIME: count_d = load_q;
                ST_COUNT: begin
                    if (count_q == CNT_W'(1))  count_d = periodic ? load_q : '0;
                    else if (count_q == '0)    count_d = load_q;
                    else                       count_d = count_q - 1'b1;
                end
                default: count_d = count_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            run_q   <= 1'b0;
            ien_q   <= 1'b0;
            mode_q  <= '0;
            psc_q   <= '0;
            load_q  <= '0;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            run_q   <= run_d;
            count_q <= count_d;
            if (ctrl_we) begin
                ien_q  <= wr_ien;
                mode_q <= wr_mode;
                psc_q  <= wr_psc;
            end
            if (load_we) load_q <= wr_load;
        end
    end

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic && !ctrl_we) |=> (state_q == ST_IDLE && !run_q && count_q == '0));
    // R8
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(count_q));
    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - 1'b1));
    // R9
    prime_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME && tick) |=> (count_q == $past(load_q)));
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
    import dct_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int PSC_W  = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        irq
);
    logic [NUM_TMR-1:0] run_w, ien_w, expire_w, clr_hit;
    logic [NUM_TMR-1:0] flag_q;
    logic [1:0]         mode_w  [NUM_TMR];
    logic [PSC_W-1:0]   psc_w   [NUM_TMR];
    logic [CNT_W-1:0]   load_w  [NUM_TMR];
    logic [CNT_W-1:0]   count_w [NUM_TMR];
    logic [31:0]        ctrl_rd [NUM_TMR];
    logic               unused_bits;

    assign unused_bits = ^{bus_wdata[31], bus_wdata[26:CNT_W], count_w[0]};

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic ctrl_sel, load_sel;
        assign ctrl_sel   = bus_we && (bus_addr == ADDR_W'(OFF_CTRL + 4 * i));
        assign load_sel   = bus_we && (bus_addr == ADDR_W'(OFF_LOAD + 4 * i));
        assign clr_hit[i] = bus_we && (bus_addr == ADDR_W'(OFF_FLAGS)) && bus_wdata[i];

        dct_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_sel),
            .load_we (load_sel),
            .wr_run  (bus_wdata[RUN_BIT]),
            .wr_ien  (bus_wdata[IEN_BIT]),
            .wr_mode (bus_wdata[MODE_LO+1:MODE_LO]),
            .wr_psc  (bus_wdata[PSC_W-1:0]),
            .wr_load (bus_wdata[CNT_W-1:0]),
            .run_q   (run_w[i]),
            .ien_q   (ien_w[i]),
            .mode_q  (mode_w[i]),
            .psc_q   (psc_w[i]),
            .load_q  (load_w[i]),
            .count_q (count_w[i]),
            .expire  (expire_w[i])
        );

        always_comb begin
            ctrl_rd[i]                      = '0;
            ctrl_rd[i][RUN_BIT]             = run_w[i];
            ctrl_rd[i][IEN_BIT]             = ien_w[i];
            ctrl_rd[i][MODE_LO+1:MODE_LO]   = mode_w[i];
            ctrl_rd[i][PSC_W-1:0]           = psc_w[i];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)            flag_q[i] <= 1'b0;
            else if (expire_w[i])  flag_q[i] <= 1'b1;
            else if (clr_hit[i])   flag_q[i] <= 1'b0;
        end

        assign irq[i] = flag_q[i] & ien_w[i];

        // R6
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire_w[i] |=> flag_q[i]);
        // R7
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[i] && !expire_w[i]) |=> !flag_q[i]);
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_CTRL):      bus_rdata = ctrl_rd[0];
            ADDR_W'(OFF_CTRL + 4):  bus_rdata = ctrl_rd[1];
            ADDR_W'(OFF_LOAD):      bus_rdata = 32'(load_w[0]);
            ADDR_W'(OFF_LOAD + 4):  bus_rdata = 32'(load_w[1]);
            ADDR_W'(OFF_CNT1):      bus_rdata = 32'(count_w[1]);
            ADDR_W'(OFF_FLAGS):     bus_rdata = 32'(flag_q);
            default:                bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/dual_countdown_timer_bench.sv
`timescale 1ns/1ps
module dual_countdown_timer_bench;
    localparam logic [31:0] RUN = 32'h4000_0000;
    localparam logic [31:0] IEN = 32'h2000_0000;
    localparam logic [31:0] PER = 32'h0800_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [1:0]  irq;
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int e0 = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_countdown_timer u_dual_countdown_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #0.5;
        we = 1'b0;
        e0 = cyc;
    endtask

    task automatic wr_at(input int target, input logic [4:0] a, input logic [31:0] d);
        do @(negedge clk); while (cyc < target - 1);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #0.5;
        we = 1'b0;
    endtask

    task automatic at_rel(input int k);
        do @(negedge clk); while (cyc < e0 + k);
    endtask

    task automatic wait_bit(input logic [4:0] a, input int b, output int delta);
        logic [31:0] v;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            rd(a, v);
            if (v[b]) break;
        end
        delta = cyc - e0;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, held;
        int d, base;
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        foreach (v[i]) begin end
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            chk($sformatf("R1 reset read 0x%0h", a), v, 0);
        end
        chk("R1 irq after reset", 32'(irq), 0);

        // R2 field layout and unmapped offsets
        wr(5'h00, 32'hBFFF_FFFF);
        rd(5'h00, v); chk("R2 ctrl0 fields", v, 32'h3800_00FF);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, v); chk("R2 load0 width", v, 32'h00FF_FFFF);
        rd(5'h10, v); chk("R2 unmapped 0x10", v, 0);
        rd(5'h1C, v); chk("R2 unmapped 0x1C", v, 0);
        rd(5'h02, v); chk("R2 unmapped 0x02", v, 0);
        wr(5'h00, 32'h0);

        // R4 one-shot sweep on timer 1
        for (int p = 0; p < 4; p++) begin
            for (int l = 1; l < 5; l++) begin
                wr(5'h0C, 32'(l));
                wr(5'h04, RUN | 32'(p));
                wait_bit(5'h18, 1, d);
                chk($sformatf("R4 one-shot delay P=%0d L=%0d", p, l), 32'(d), 32'((l + 1) * (p + 1)));
                rd(5'h04, v); chk("R4 enable self-cleared", 32'(v[30]), 0);
                rd(5'h14, v); chk("R4 count zero after stop", v, 0);
                wr(5'h18, 32'h2);
            end
        end
        // R11 timer 0 untouched by timer 1 activity
        rd(5'h18, v); chk("R11 flag0 unaffected", 32'(v[0]), 0);

        // R3 count trace, timer 1, P=2 L=30
        wr(5'h0C, 32'd30);
        wr(5'h04, RUN | 32'd2);
        for (int k = 1; k <= 40; k++) begin
            at_rel(k);
            rd(5'h14, v);
            chk($sformatf("R3 count at +%0d", k), v, (k / 3 == 0) ? 0 : 32'(31 - k / 3));
        end

        // R8 pause and resume
        wr(5'h04, 32'd2);
        repeat (2) @(negedge clk);
        rd(5'h14, held);
        repeat (10) @(negedge clk);
        rd(5'h14, v); chk("R8 count frozen while stopped", v, held);
        wr(5'h04, RUN | 32'd2);
        at_rel(2); rd(5'h14, v); chk("R8 no step before P+1", v, held);
        at_rel(3); rd(5'h14, v); chk("R8 first step at P+1", v, held - 1);
        wr(5'h04, 32'd0);

        // R5 R6 R7 periodic timer 0 with interrupt, P=1 L=3
        rd(5'h14, held);
        wr(5'h08, 32'd3);
        wr(5'h00, RUN | IEN | PER | 32'd1);
        base = e0;
        wait_bit(5'h18, 0, d);
        chk("R4 periodic first expiry", 32'(d), 8);
        chk("R6 irq0 follows flag", 32'(irq[0]), 1);
        wr(5'h18, 32'h1);
        @(negedge clk);
        chk("R7 irq0 low after clear", 32'(irq[0]), 0);
        rd(5'h18, v); chk("R7 flag0 cleared", 32'(v[0]), 0);
        e0 = base;
        wait_bit(5'h18, 0, d);
        chk("R5 second expiry", 32'(d), 14);
        wr(5'h18, 32'h2);
        rd(5'h18, v); chk("R7 zero bit leaves flag0", 32'(v[0]), 1);
        wr(5'h18, 32'h1);
        e0 = base;
        wait_bit(5'h18, 0, d);
        chk("R5 third expiry", 32'(d), 20);
        rd(5'h14, v); chk("R11 count1 unaffected by timer 0", v, held);
        wr(5'h00, 32'd0);
        wr(5'h18, 32'h1);

        // R7 same-cycle set and clear, P=0 L=3: expiries at +4, +7, +10
        wr(5'h08, 32'd3);
        wr(5'h00, RUN | PER);
        base = e0;
        wr_at(base + 5, 5'h18, 32'h1);
        @(negedge clk); rd(5'h18, v); chk("R7 clear off expiry", 32'(v[0]), 0);
        wr_at(base + 7, 5'h18, 32'h1);
        @(negedge clk); rd(5'h18, v); chk("R7 expiry wins over clear", 32'(v[0]), 1);
        wr_at(base + 8, 5'h18, 32'h1);
        @(negedge clk); rd(5'h18, v); chk("R7 later clear", 32'(v[0]), 0);
        wr(5'h00, 32'd0);
        wr(5'h18, 32'h1);

        // R6 flag without interrupt enable
        wr(5'h0C, 32'd2);
        wr(5'h04, RUN);
        wait_bit(5'h18, 1, d);
        chk("R6 flag1 sets with ien off", 32'(d), 3);
        chk("R6 irq1 stays low", 32'(irq[1]), 0);
        wr(5'h04, IEN);
        @(negedge clk);
        chk("R6 irq1 rises with ien", 32'(irq[1]), 1);
        wr(5'h18, 32'h2);
        @(negedge clk);
        chk("R6 irq1 drops on clear", 32'(irq[1]), 0);

        // R9 reload write while running, P=0
        wr(5'h0C, 32'd50);
        wr(5'h04, RUN | PER);
        repeat (10) @(negedge clk);
        wr(5'h0C, 32'd7);
        at_rel(1); rd(5'h14, v); chk("R9 new value loaded on next tick", v, 7);
        at_rel(2); rd(5'h14, v); chk("R9 counting from new value", v, 6);
        wr(5'h04, 32'd0);
        wr(5'h18, 32'h3);

        // R10 reload of zero never expires
        wr(5'h0C, 32'd0);
        wr(5'h04, RUN);
        repeat (60) @(negedge clk);
        rd(5'h18, v); chk("R10 no expiry with zero reload", 32'(v[1]), 0);
        rd(5'h04, v); chk("R10 enable stays set", 32'(v[30]), 1);
        rd(5'h14, v); chk("R10 count stays zero", v, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule